// File: doc/BRIEF.md
# Programmable Down-Counting Interval Timer

A single register-mapped timer for a simple 32-bit bus with select, write strobe, byte address, write data and read data. A down-counter advances on ticks from a prescaler that divides the clock by 1, 16 or 256. The counter is 16 or 32 bits wide and has three behaviours at zero. In free-running mode it wraps to all ones. In periodic mode it reloads a programmed value. In one-shot mode it parks at zero.

When the counter reaches zero it sets a raw interrupt flag. Software clears that flag by writing any data to a clear register. An enable bit gates the raw flag to form the masked status and the interrupt output. A reload value can be written in two ways. The immediate form also restarts the count. The background form changes only the value used at the next reload.

Reads are combinational: `rdata_o` reflects the addressed register in the same cycle that `sel_i` is high. Register writes take effect at the next rising clock edge.

Top module: `interval_timer`

## Requirements
- R1: After reset the control register reads 0x20, the load and current value read 0xFFFFFFFF, raw and masked status read 0, and `irq_o` is low.
- R2: Byte offsets are 0x00 load, 0x04 current value, 0x08 control, 0x0C interrupt clear, 0x10 raw status (bit 0), 0x14 masked status (bit 0), 0x18 background load. The background offset reads the reload value. The clear offset, offsets 0x1C and above, and any address with bits [1:0] nonzero read 0. `rdata_o` is 0 while `sel_i` is low.
- R3: The control register holds bit 0 one-shot, bit 1 full 32-bit size (clear means 16-bit), bits [3:2] prescale, bit 5 interrupt enable, bit 6 periodic and bit 7 run. Bit 4 and bits 31:8 are not stored and read as 0.
- R4: The prescale field selects the counting rate. With 00 (or 11) the counter counts on every cycle, with 01 on every 16th cycle, and with 10 on every 256th cycle. The prescaler phase is held at zero while stopped, so with divider D the k-th decrement lands k·D edges after the edge that writes run=1.
- R5: A write to 0x00 sets both the reload value and the counter at the next edge, and it overrides any tick in that cycle. A write to 0x18 changes only the reload value.
- R6: In periodic mode, a tick taken while the counter is at zero loads the reload value. The period is therefore reload+1 ticks.
- R7: In free-running mode (one-shot and periodic both clear), a tick at zero wraps the counter to 0xFFFFFFFF in 32-bit mode, or sets the low half to 0xFFFF in 16-bit mode.
- R8: In one-shot mode the counter stays at zero on later ticks until the load register is written. One-shot takes priority over periodic.
- R9: In 16-bit mode only bits [15:0] count, bits [31:16] keep their value, and zero is detected on the low half.
- R10: The raw flag is set on the tick that moves the counter from nonzero to zero. A write of any data to 0x0C clears it. If a set and a clear fall in the same cycle, the set wins.
- R11: Masked status equals raw status AND interrupt enable, and `irq_o` equals masked status.
- R12: While run is 0 the counter holds its value, and writes to the current-value offset are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Register access select |
| wr_i | input | 1 | Write strobe, valid with sel_i |
| addr_i | input | ADDR_W (8) | Byte address |
| wdata_i | input | CNT_W (32) | Write data |
| rdata_o | output | CNT_W (32) | Read data, combinational |
| irq_o | output | 1 | Masked interrupt |

## Verification
Read data is combinational, so the bench samples it 1 ns after driving the address at a falling edge, before the next rising edge. A write is visible after exactly one rising edge. With divider D, the counter's k-th decrement lands k·D edges after the edge that sets run, and the bench counts its idle cycles from that edge. A control write made while running also consumes one tick from the old settings, and the expected values include it. The bench compares values only at cycle counts that fall just before or just after a decrement, zero crossing or reload, so an off-by-one in the prescaler or in the reload shows up as a mismatch.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int IDX_LOAD  = 0;
  localparam int IDX_VALUE = 1;
  localparam int IDX_CTRL  = 2;
  localparam int IDX_CLR   = 3;
  localparam int IDX_RIS   = 4;
  localparam int IDX_MIS   = 5;
  localparam int IDX_BG    = 6;

  typedef enum logic [1:0] {
    PRE_DIV1   = 2'b00,
    PRE_DIV16  = 2'b01,
    PRE_DIV256 = 2'b10,
    PRE_RSVD   = 2'b11
  } pre_sel_e;

  typedef struct packed {
    logic     run;
    logic     periodic;
    logic     ie;
    logic     rsvd;
    pre_sel_e pre;
    logic     size_full;
    logic     oneshot;
  } ctrl_t;

  localparam logic [7:0] CTRL_RST   = 8'h20;
  localparam logic [7:0] CTRL_WMASK = 8'hEF;
endpackage

// File: rtl/timer_prescaler.sv
module timer_prescaler import timer_pkg::*; #(
  parameter int MID_LOG2 = 4,
  parameter int TOP_LOG2 = 8
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     run_i,
  input  pre_sel_e sel_i,
  output logic     tick_o
);
  logic [TOP_LOG2-1:0] phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     phase_q <= '0;
    else if (!run_i) phase_q <= '0;
    else             phase_q <= phase_q + 1'b1;
  end

  always_comb begin
    unique case (sel_i)
      PRE_DIV16:  tick_o = run_i && (phase_q[MID_LOG2-1:0] == '1);
      PRE_DIV256: tick_o = run_i && (phase_q == '1);
      default:    tick_o = run_i;
    endcase
  end
endmodule

// File: rtl/timer_counter.sv
module timer_counter #(
  parameter int CNT_W  = 32,
  parameter int HALF_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             size_full_i,
  input  logic             oneshot_i,
  input  logic             periodic_i,
  input  logic             load_we_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit_o
);
  localparam int UP_W = CNT_W - HALF_W;

  logic [CNT_W-1:0]  cnt_q, cnt_nxt;
  logic [HALF_W-1:0] low;
  logic [UP_W-1:0]   up;
  logic              at_zero, at_one;

  assign low = cnt_q[HALF_W-1:0];
  assign up  = cnt_q[CNT_W-1:HALF_W];

  always_comb begin
    at_zero = size_full_i ? (cnt_q == '0) : (low == '0);
    at_one  = size_full_i ? (cnt_q == CNT_W'(1)) : (low == HALF_W'(1));
  end

  always_comb begin
    cnt_nxt = cnt_q;
    if (tick_i) begin
      if (!at_zero) begin
        cnt_nxt = size_full_i ? cnt_q - 1'b1 : {up, low - 1'b1};
      end else if (oneshot_i) begin
        cnt_nxt = cnt_q;               // parked until reloaded
      end else if (periodic_i) begin
        cnt_nxt = reload_i;
      end else begin
        cnt_nxt = size_full_i ? '1 : {up, {HALF_W{1'b1}}};
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '1;
    else if (load_we_i) cnt_q <= load_val_i;
    else                cnt_q <= cnt_nxt;
  end

  assign cnt_o = cnt_q;
  assign hit_o = tick_i && !at_zero && at_one && !load_we_i;
endmodule

// File: rtl/timer_irq.sv
module timer_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic clr_i,
  input  logic ie_i,
  output logic raw_o,
  output logic irq_o
);
  logic raw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    raw_q <= 1'b0;
    else if (hit_i) raw_q <= 1'b1;   // set beats clear
    else if (clr_i) raw_q <= 1'b0;
  end

  assign raw_o = raw_q;
  assign irq_o = raw_q && ie_i;
endmodule

// File: rtl/interval_timer.sv
module interval_timer import timer_pkg::*; #(
  parameter int ADDR_W   = 8,
  parameter int CNT_W    = 32,
  parameter int HALF_W   = 16,
  parameter int MID_LOG2 = 4,
  parameter int TOP_LOG2 = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  output logic              irq_o
);
  localparam int WORD_W = ADDR_W - 2;
  localparam logic [WORD_W-1:0] W_LOAD  = WORD_W'(IDX_LOAD);
  localparam logic [WORD_W-1:0] W_VALUE = WORD_W'(IDX_VALUE);
  localparam logic [WORD_W-1:0] W_CTRL  = WORD_W'(IDX_CTRL);
  localparam logic [WORD_W-1:0] W_CLR   = WORD_W'(IDX_CLR);
  localparam logic [WORD_W-1:0] W_RIS   = WORD_W'(IDX_RIS);
  localparam logic [WORD_W-1:0] W_MIS   = WORD_W'(IDX_MIS);
  localparam logic [WORD_W-1:0] W_BG    = WORD_W'(IDX_BG);

  logic [WORD_W-1:0] word;
  logic              acc, wr_acc;
  logic              we_load, we_ctrl, we_clr, we_bg;
  ctrl_t             ctrl_q;
  logic [CNT_W-1:0]  load_q;
  logic [CNT_W-1:0]  cnt_w;
  logic              tick_w, hit_w, raw_w, irq_w;
  logic              run_w, oneshot_w, periodic_w, size_full_w, ie_w;

  assign word   = addr_i[ADDR_W-1:2];
  assign acc    = sel_i && (addr_i[1:0] == 2'b00);
  assign wr_acc = acc && wr_i;

  always_comb begin
    we_load = wr_acc && (word == W_LOAD);
    we_ctrl = wr_acc && (word == W_CTRL);
    we_clr  = wr_acc && (word == W_CLR);
    we_bg   = wr_acc && (word == W_BG);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= ctrl_t'(CTRL_RST);
    else if (we_ctrl) ctrl_q <= ctrl_t'(wdata_i[7:0] & CTRL_WMASK);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                load_q <= '1;
    else if (we_load || we_bg)  load_q <= wdata_i;
  end

  assign run_w       = ctrl_q.run;
  assign oneshot_w   = ctrl_q.oneshot;
  assign periodic_w  = ctrl_q.periodic;
  assign size_full_w = ctrl_q.size_full;
  assign ie_w        = ctrl_q.ie;

  timer_prescaler #(
    .MID_LOG2 (MID_LOG2),
    .TOP_LOG2 (TOP_LOG2)
  ) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_w),
    .sel_i  (ctrl_q.pre),
    .tick_o (tick_w)
  );

  timer_counter #(
    .CNT_W  (CNT_W),
    .HALF_W (HALF_W)
  ) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_w),
    .size_full_i (size_full_w),
    .oneshot_i   (oneshot_w),
    .periodic_i  (periodic_w),
    .load_we_i   (we_load),
    .load_val_i  (wdata_i),
    .reload_i    (load_q),
    .cnt_o       (cnt_w),
    .hit_o       (hit_w)
  );

  timer_irq u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hit_i  (hit_w),
    .clr_i  (we_clr),
    .ie_i   (ie_w),
    .raw_o  (raw_w),
    .irq_o  (irq_w)
  );

  always_comb begin
    rdata_o = '0;
    if (acc) begin
      unique case (word)
        W_LOAD, W_BG: rdata_o = load_q;
        W_VALUE:      rdata_o = cnt_w;
        W_CTRL:       rdata_o = CNT_W'(ctrl_q);
        W_RIS:        rdata_o = CNT_W'(raw_w);
        W_MIS:        rdata_o = CNT_W'(irq_w);
        default:      rdata_o = '0;
      endcase
    end
  end

  assign irq_o = irq_w;
endmodule

// File: rtl/timer_sva.sv
module timer_sva #(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 32,
  parameter int HALF_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sel_i,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [CNT_W-1:0]  wdata_i,
  input logic [CNT_W-1:0]  rdata_o,
  input logic              irq_o,
  input logic [CNT_W-1:0]  cnt_i,
  input logic              raw_i,
  input logic              tick_i,
  input logic              run_i,
  input logic              oneshot_i,
  input logic              size_full_i
);
  logic acc, w_load, w_bg, w_clr, rd_mis, unmapped, parked;

  assign acc      = sel_i && (addr_i[1:0] == 2'b00);
  assign w_load   = acc && wr_i && (addr_i[ADDR_W-1:2] == '0);
  assign w_bg     = acc && wr_i && (addr_i[ADDR_W-1:2] == (ADDR_W-2)'(6));
  assign w_clr    = acc && wr_i && (addr_i[ADDR_W-1:2] == (ADDR_W-2)'(3));
  assign rd_mis   = acc && !wr_i && (addr_i[ADDR_W-1:2] == (ADDR_W-2)'(5));
  assign unmapped = sel_i && (addr_i[ADDR_W-1:2] > (ADDR_W-2)'(6));
  assign parked   = run_i && oneshot_i &&
                    (size_full_i ? (cnt_i == '0) : (cnt_i[HALF_W-1:0] == '0));

  AST_LOAD_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w_load |=> (cnt_i == $past(wdata_i)));                          // R5
  AST_BG_KEEPS_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w_bg && !tick_i) |=> $stable(cnt_i));                          // R5
  AST_STOPPED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !w_load) |=> $stable(cnt_i));                        // R12
  AST_ONESHOT_PARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (parked && !w_load) |=> $stable(cnt_i));                        // R8
  AST_CLEAR_RAW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w_clr && !tick_i) |=> !raw_i);                                 // R10
  AST_RAW_NEEDS_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(raw_i) |-> $past(tick_i));                                // R10
  AST_MIS_MATCHES_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_mis |-> (rdata_o[0] == irq_o));                              // R11
  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unmapped |-> (rdata_o == '0));                                  // R2
endmodule

bind interval_timer timer_sva #(
  .ADDR_W (ADDR_W),
  .CNT_W  (CNT_W),
  .HALF_W (HALF_W)
) u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sel_i       (sel_i),
  .wr_i        (wr_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .rdata_o     (rdata_o),
  .irq_o       (irq_o),
  .cnt_i       (cnt_w),
  .raw_i       (raw_w),
  .tick_i      (tick_w),
  .run_i       (run_w),
  .oneshot_i   (oneshot_w),
  .size_full_i (size_full_w)
);

// File: tb/tb_interval_timer.sv
`timescale 1ns/1ps
module tb_interval_timer;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sel_i = 1'b0;
  logic        wr_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  interval_timer dut (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (sel_i),
    .wr_i    (wr_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .irq_o   (irq_o)
  );

  localparam logic [7:0] A_LOAD = 8'h00, A_VAL = 8'h04, A_CTRL = 8'h08, A_CLR = 8'h0C,
                         A_RIS = 8'h10, A_MIS = 8'h14, A_BG = 8'h18;
  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_IDLE = 2'd2;

  typedef struct packed {
    logic [1:0]  op;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [7:0]  req;
  } vec_t;

  localparam int NVEC = 63;
  localparam vec_t VEC [NVEC] = '{
    '{OP_WR,   A_CTRL, 32'h0,        8'd12},
    '{OP_WR,   A_LOAD, 32'd10,       8'd5},   // R5
    '{OP_RD,   A_LOAD, 32'd10,       8'd5},
    '{OP_RD,   A_VAL,  32'd10,       8'd5},
    '{OP_WR,   A_CTRL, 32'hE2,       8'd3},   // R3 run|periodic|ie|32-bit
    '{OP_IDLE, 8'h0,   32'd4,        8'd4},
    '{OP_RD,   A_VAL,  32'd6,        8'd4},   // R4 divide by 1
    '{OP_IDLE, 8'h0,   32'd6,        8'd6},
    '{OP_RD,   A_VAL,  32'd0,        8'd6},
    '{OP_RD,   A_RIS,  32'd1,        8'd10},  // R10
    '{OP_RD,   A_MIS,  32'd1,        8'd11},  // R11
    '{OP_IDLE, 8'h0,   32'd1,        8'd6},
    '{OP_RD,   A_VAL,  32'd10,       8'd6},   // R6 reload
    '{OP_WR,   A_CLR,  32'hDEAD,     8'd10},
    '{OP_RD,   A_RIS,  32'd0,        8'd10},
    '{OP_WR,   A_BG,   32'd5,        8'd5},
    '{OP_RD,   A_LOAD, 32'd5,        8'd5},
    '{OP_RD,   A_VAL,  32'd8,        8'd5},   // R5 background leaves count
    '{OP_IDLE, 8'h0,   32'd8,        8'd6},
    '{OP_RD,   A_VAL,  32'd0,        8'd6},
    '{OP_IDLE, 8'h0,   32'd1,        8'd6},
    '{OP_RD,   A_VAL,  32'd5,        8'd6},   // R6 new reload
    '{OP_WR,   A_CTRL, 32'h0,        8'd12},
    '{OP_RD,   A_CTRL, 32'h0,        8'd3},
    '{OP_IDLE, 8'h0,   32'd5,        8'd12},
    '{OP_RD,   A_VAL,  32'd4,        8'd12},  // R12 stopped holds
    '{OP_WR,   A_CLR,  32'h0,        8'd10},
    '{OP_RD,   A_RIS,  32'd0,        8'd10},
    '{OP_WR,   A_VAL,  32'h1234,     8'd12},
    '{OP_RD,   A_VAL,  32'd4,        8'd12},  // R12 value write ignored
    '{OP_WR,   A_LOAD, 32'd2,        8'd7},
    '{OP_WR,   A_CTRL, 32'h82,       8'd7},   // R7 free 32-bit, ie off
    '{OP_IDLE, 8'h0,   32'd2,        8'd7},
    '{OP_RD,   A_VAL,  32'd0,        8'd7},
    '{OP_RD,   A_RIS,  32'd1,        8'd10},
    '{OP_RD,   A_MIS,  32'd0,        8'd11},  // R11 masked
    '{OP_IDLE, 8'h0,   32'd1,        8'd7},
    '{OP_RD,   A_VAL,  32'hFFFFFFFF, 8'd7},   // R7 wrap
    '{OP_WR,   A_CLR,  32'h1,        8'd10},
    '{OP_RD,   A_VAL,  32'hFFFFFFFE, 8'd7},
    '{OP_WR,   A_CTRL, 32'h0,        8'd12},
    '{OP_WR,   A_LOAD, 32'hABCD0002, 8'd9},   // R9
    '{OP_WR,   A_CTRL, 32'h80,       8'd9},   // 16-bit free
    '{OP_IDLE, 8'h0,   32'd2,        8'd9},
    '{OP_RD,   A_VAL,  32'hABCD0000, 8'd9},
    '{OP_RD,   A_RIS,  32'd1,        8'd9},
    '{OP_IDLE, 8'h0,   32'd1,        8'd9},
    '{OP_RD,   A_VAL,  32'hABCDFFFF, 8'd9},   // R9 upper half kept
    '{OP_WR,   A_CTRL, 32'h0,        8'd12},
    '{OP_WR,   A_CLR,  32'h0,        8'd10},
    '{OP_WR,   A_LOAD, 32'd3,        8'd8},
    '{OP_WR,   A_CTRL, 32'hE3,       8'd8},   // R8 one-shot over periodic
    '{OP_IDLE, 8'h0,   32'd3,        8'd8},
    '{OP_RD,   A_VAL,  32'd0,        8'd8},
    '{OP_RD,   A_RIS,  32'd1,        8'd10},
    '{OP_IDLE, 8'h0,   32'd5,        8'd8},
    '{OP_RD,   A_VAL,  32'd0,        8'd8},   // R8 parked
    '{OP_WR,   A_LOAD, 32'd2,        8'd8},
    '{OP_RD,   A_VAL,  32'd2,        8'd8},
    '{OP_IDLE, 8'h0,   32'd2,        8'd8},
    '{OP_RD,   A_VAL,  32'd0,        8'd8},
    '{OP_WR,   A_CTRL, 32'h0,        8'd12},
    '{OP_WR,   A_CLR,  32'h0,        8'd10}
  };

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    sel_i = 1'b1; wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    sel_i = 1'b0; wr_i = 1'b0;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
    sel_i = 1'b1; wr_i = 1'b0; addr_i = a;
    #1;
    chk(req, rdata_o, exp);
    sel_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    rd("R1", A_CTRL, 32'h20);
    rd("R1", A_LOAD, 32'hFFFFFFFF);
    rd("R1", A_VAL,  32'hFFFFFFFF);
    rd("R1", A_RIS,  32'h0);
    rd("R1", A_MIS,  32'h0);
    chk("R1", {31'b0, irq_o}, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      case (VEC[i].op)
        OP_WR:   wr(VEC[i].addr, VEC[i].data);
        OP_RD:   rd($sformatf("R%0d", VEC[i].req), VEC[i].addr, VEC[i].data);
        default: idle(int'(VEC[i].data));
      endcase
    end

    // R4 divide by 16
    wr(A_LOAD, 32'd100);
    wr(A_CTRL, 32'h86);
    idle(15);
    rd("R4", A_VAL, 32'd100);
    idle(1);
    rd("R4", A_VAL, 32'd99);
    idle(32);
    rd("R4", A_VAL, 32'd97);
    wr(A_CTRL, 32'h0);
    rd("R12", A_VAL, 32'd97);

    // R4 divide by 256
    wr(A_LOAD, 32'd5);
    wr(A_CTRL, 32'h8A);
    idle(255);
    rd("R4", A_VAL, 32'd5);
    idle(1);
    rd("R4", A_VAL, 32'd4);
    wr(A_CTRL, 32'h0);

    // R10 set wins over clear in the same cycle
    wr(A_LOAD, 32'd2);
    wr(A_CTRL, 32'h82);
    idle(1);
    wr(A_CLR, 32'h0);
    rd("R10", A_RIS, 32'd1);
    rd("R10", A_VAL, 32'd0);

    // R11 irq follows raw AND enable
    chk("R11", {31'b0, irq_o}, 32'h0);
    wr(A_CTRL, 32'hA2);
    chk("R11", {31'b0, irq_o}, 32'h1);
    wr(A_CTRL, 32'h20);
    chk("R11", {31'b0, irq_o}, 32'h1);
    wr(A_CLR, 32'h5A5A5A5A);
    chk("R11", {31'b0, irq_o}, 32'h0);

    // R2 decode corners
    rd("R2", A_CLR, 32'h0);
    rd("R2", 8'h1C, 32'h0);
    rd("R2", 8'h3C, 32'h0);
    rd("R2", 8'h09, 32'h0);
    rd("R2", A_BG,  32'd2);
    addr_i = A_LOAD; sel_i = 1'b0; wr_i = 1'b0;
    #1;
    chk("R2", rdata_o, 32'h0);

    // R3 unstored control bits
    wr(A_CTRL, 32'hFFFFFF7F);
    rd("R3", A_CTRL, 32'h6F);
    wr(A_CTRL, 32'h0);

    summary();
  end
endmodule